// File: doc/BRIEF.md
# I/O Port Permission Guard

The guard decides, for every I/O port access a task makes, whether the access may proceed or must raise a protection fault. It holds one permission bit for each of the 65536 ports of the I/O space. A cleared bit opens a port and a set bit closes it. It also holds the task's I/O privilege level. When that level is above the privilege level of the access, the guard allows the access without reading the bitmap.

Software opens and closes ports with range commands. Each command names a base port and a log2 port count, and the base must be aligned to the range size. A writer applies the range to the bitmap one 128-bit word per clock, and the guard reports busy while it does. Granting the whole port space promotes the task to the highest I/O privilege level. Revoking any port afterwards demotes it again. A task switch loads a new privilege level and closes every port in one clock.

Top module: `io_port_guard`

## Requirements
- R1: After reset every port is closed and `iopl` reads 0. A `task_sw` pulse closes every port, loads `iopl` from `task_iopl` on the next clock and abandons any range update in progress.
- R2: With `iopl` not above `acc_cpl`, a 1-byte access to a port whose permission bit is 0 (open) is allowed. An access to a port whose bit is 1 (closed) faults.
- R3: When `iopl` is greater than `acc_cpl`, an in-range access of a legal size is allowed whatever the bitmap holds.
- R4: An access is accepted when `acc_valid` is high and `busy` and `task_sw` are low. Exactly one clock later, `rsp_valid` is high with `rsp_allow` giving the verdict. `rsp_valid` is low in every other cycle.
- R5: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. A multi-byte access is allowed by the bitmap only when every consecutive port it touches is open. This holds across a 128-port word boundary. Code 3 always faults.
- R6: An access whose last touched port would lie beyond 0xFFFF faults, even when the privilege bypass applies.
- R7: A command with `cmd_grant` = 1 opens, and with `cmd_grant` = 0 closes, exactly the ports `cmd_base` to `cmd_base + 2^cmd_log2 - 1`. Other ports are left as they were.
- R8: A command whose `cmd_log2` exceeds 16, or whose `cmd_base` is not a multiple of `2^cmd_log2`, pulses `cmd_err` one clock after acceptance. It leaves the bitmap unchanged and does not raise `busy`.
- R9: A legal command raises `busy` from the next clock for max(1, 2^(cmd_log2-7)) cycles. Accesses and commands presented while `busy` is high get no response and have no effect.
- R10: When a grant leaves all 65536 ports open, `iopl` reads 3 from the cycle in which `busy` falls.
- R11: Accepting a legal revoke while `iopl` is 3 sets `iopl` to 0 on the next clock.
- R12: In a cycle with `task_sw` high, a simultaneous access gets no response and a simultaneous command is dropped without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_sw | input | 1 | Task switch: close all ports, load privilege |
| task_iopl | input | 2 | Privilege level of the incoming task |
| acc_valid | input | 1 | Access request valid |
| acc_port | input | 16 | First port of the access |
| acc_size | input | 2 | Access width code (0:1, 1:2, 2:4 bytes) |
| acc_cpl | input | 2 | Current privilege level of the access |
| cmd_valid | input | 1 | Range command valid |
| cmd_grant | input | 1 | 1 opens the range, 0 closes it |
| cmd_base | input | 16 | First port of the range |
| cmd_log2 | input | 5 | log2 of the range size |
| busy | output | 1 | Range update in progress |
| rsp_valid | output | 1 | Access verdict valid |
| rsp_allow | output | 1 | 1 allow, 0 protection fault |
| cmd_err | output | 1 | Rejected command pulse |
| iopl | output | 2 | Current task I/O privilege level |

## Verification
An access and a range command can be accepted in the same idle cycle. The access must then be judged on the bitmap and privilege level as they stood before the command. The bench provokes this by revoking a port in the very cycle it reads that port, then reading it again after the update. A task switch can also coincide with an access, a command, or an update that is halfway done. The bench pairs each of these with the switch. A behavioural model scores every cycle and expects the switch to win.

// File: rtl/io_port_guard.sv
module io_port_guard #(
  parameter int PORT_W = 16,
  parameter int WORD_W = 128,
  parameter int LVL_W  = 2,
  parameter int LOG_W  = $clog2(PORT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_sw,
  input  logic [LVL_W-1:0]  task_iopl,
  input  logic              acc_valid,
  input  logic [PORT_W-1:0] acc_port,
  input  logic [1:0]        acc_size,
  input  logic [LVL_W-1:0]  acc_cpl,
  input  logic              cmd_valid,
  input  logic              cmd_grant,
  input  logic [PORT_W-1:0] cmd_base,
  input  logic [LOG_W-1:0]  cmd_log2,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              cmd_err,
  output logic [LVL_W-1:0]  iopl
);
  localparam int OFF_W  = $clog2(WORD_W);
  localparam int IDX_W  = PORT_W - OFF_W;
  localparam int NWORDS = 1 << IDX_W;
  localparam int CNT_W  = IDX_W + 1;

  logic [WORD_W-1:0] mem [NWORDS];
  logic [NWORDS-1:0] stale_q, zero_q, zero_nxt;
  logic              upd_on_q, upd_grant_q;
  logic [IDX_W-1:0]  upd_idx_q;
  logic [CNT_W-1:0]  upd_left_q;
  logic [WORD_W-1:0] upd_mask_q;
  logic [LVL_W-1:0]  iopl_q;
  logic              rsp_valid_q, rsp_allow_q, cmd_err_q;

  logic acc_go, cmd_go;
  assign acc_go = acc_valid & ~upd_on_q & ~task_sw;
  assign cmd_go = cmd_valid & ~upd_on_q & ~task_sw;

  // range command decode
  logic [PORT_W:0]   span;
  logic [PORT_W-1:0] align_m;
  logic              cmd_bad;
  logic [WORD_W-1:0] lo_ones, new_mask;
  logic [CNT_W-1:0]  new_cnt;

  assign span     = (PORT_W+1)'(1) << cmd_log2;
  assign align_m  = PORT_W'(span - (PORT_W+1)'(1));
  assign cmd_bad  = (cmd_log2 > LOG_W'(PORT_W)) | (|(cmd_base & align_m));
  assign lo_ones  = (WORD_W'(1) << span) - WORD_W'(1);
  assign new_mask = lo_ones << cmd_base[OFF_W-1:0];
  assign new_cnt  = (cmd_log2 > LOG_W'(OFF_W)) ? CNT_W'(span >> OFF_W) : CNT_W'(1);

  // word writer
  logic [WORD_W-1:0] cur_w, nxt_w;
  assign cur_w = stale_q[upd_idx_q] ? '1 : mem[upd_idx_q];
  assign nxt_w = upd_grant_q ? (cur_w & ~upd_mask_q) : (cur_w | upd_mask_q);

  always_comb begin
    zero_nxt = zero_q;
    zero_nxt[upd_idx_q] = ~|nxt_w;
  end

  always_ff @(posedge clk)
    if (upd_on_q && !task_sw) mem[upd_idx_q] <= nxt_w;

  // access check
  logic [IDX_W-1:0]  ridx0, ridx1;
  logic [WORD_W-1:0] rw0, rw1;
  logic [3:0]        win, need;
  logic [2:0]        extra;
  logic              ovf, size_bad, bits_ok, acc_ok;

  assign ridx0 = acc_port[PORT_W-1:OFF_W];
  assign ridx1 = ridx0 + IDX_W'(1);
  assign rw0   = stale_q[ridx0] ? '1 : mem[ridx0];
  assign rw1   = stale_q[ridx1] ? '1 : mem[ridx1];
  assign win   = 4'({rw1, rw0} >> acc_port[OFF_W-1:0]);

  always_comb begin
    case (acc_size)
      2'd0:    begin need = 4'b0001; extra = 3'd0; end
      2'd1:    begin need = 4'b0011; extra = 3'd1; end
      default: begin need = 4'b1111; extra = 3'd3; end
    endcase
  end

  assign ovf      = acc_port > ({PORT_W{1'b1}} - PORT_W'(extra));
  assign size_bad = (acc_size == 2'd3);
  assign bits_ok  = ~|(win & need);
  assign acc_ok   = ~ovf & ~size_bad & ((iopl_q > acc_cpl) | bits_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q     <= '1;
      zero_q      <= '0;
      upd_on_q    <= 1'b0;
      upd_grant_q <= 1'b0;
      upd_idx_q   <= '0;
      upd_left_q  <= '0;
      upd_mask_q  <= '0;
      iopl_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_allow_q <= 1'b0;
      cmd_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= acc_go;
      rsp_allow_q <= acc_go & acc_ok;
      cmd_err_q   <= cmd_go & cmd_bad;
      if (task_sw) begin
        stale_q  <= '1;
        zero_q   <= '0;
        upd_on_q <= 1'b0;
        iopl_q   <= task_iopl;
      end else if (upd_on_q) begin
        stale_q[upd_idx_q] <= 1'b0;
        zero_q     <= zero_nxt;
        upd_idx_q  <= upd_idx_q + IDX_W'(1);
        upd_left_q <= upd_left_q - CNT_W'(1);
        if (upd_left_q == CNT_W'(1)) begin
          upd_on_q <= 1'b0;
          if (upd_grant_q && (&zero_nxt)) iopl_q <= '1;
        end
      end else if (cmd_go && !cmd_bad) begin
        upd_on_q    <= 1'b1;
        upd_grant_q <= cmd_grant;
        upd_idx_q   <= cmd_base[PORT_W-1:OFF_W];
        upd_left_q  <= new_cnt;
        upd_mask_q  <= new_mask;
        if (!cmd_grant && iopl_q == '1) iopl_q <= '0;
      end
    end
  end

  assign busy      = upd_on_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_allow = rsp_allow_q;
  assign cmd_err   = cmd_err_q;
  assign iopl      = iopl_q;
endmodule

// File: rtl/io_port_guard_chk.sv
module io_port_guard_chk #(
  parameter int PORT_W = 16,
  parameter int LVL_W  = 2,
  parameter int LOG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              task_sw,
  input logic [LVL_W-1:0]  task_iopl,
  input logic              acc_valid,
  input logic [PORT_W-1:0] acc_port,
  input logic [1:0]        acc_size,
  input logic [LVL_W-1:0]  acc_cpl,
  input logic              cmd_valid,
  input logic              cmd_grant,
  input logic [PORT_W-1:0] cmd_base,
  input logic [LOG_W-1:0]  cmd_log2,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic              cmd_err,
  input logic [LVL_W-1:0]  iopl
);
  logic        a_go, c_go, c_bad, a_ovf, a_badsz;
  logic [31:0] c_unit, a_bytes;

  assign a_go    = acc_valid && !busy && !task_sw;
  assign c_go    = cmd_valid && !busy && !task_sw;
  assign c_unit  = 32'd1 << cmd_log2;
  assign c_bad   = (int'(cmd_log2) > PORT_W) || ((32'(cmd_base) & (c_unit - 32'd1)) != 32'd0);
  assign a_bytes = (acc_size == 2'd0) ? 32'd1 : (acc_size == 2'd1) ? 32'd2 : 32'd4;
  assign a_ovf   = (32'(acc_port) + a_bytes) > (32'd1 << PORT_W);
  assign a_badsz = (acc_size == 2'd3);

  AST_RSP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) a_go |=> rsp_valid); // R4
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !a_go |=> !rsp_valid); // R9
  AST_PRIV_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_go && iopl > acc_cpl && !a_ovf && !a_badsz) |=> rsp_allow); // R3
  AST_EDGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (a_go && (a_ovf || a_badsz)) |=> !rsp_allow); // R6
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n) (c_go && c_bad) |=> (cmd_err && !busy)); // R8
  AST_GOOD_CMD: assert property (@(posedge clk) disable iff (!rst_n) (c_go && !c_bad) |=> (busy && !cmd_err)); // R9
  AST_REVOKE_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_go && !c_bad && !cmd_grant) |=> (iopl != '1)); // R11
  AST_SWITCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> (!busy && iopl == $past(task_iopl))); // R1
  AST_SWITCH_WINS: assert property (@(posedge clk) disable iff (!rst_n) task_sw |=> (!rsp_valid && !cmd_err)); // R12
endmodule

bind io_port_guard io_port_guard_chk #(.PORT_W(PORT_W), .LVL_W(LVL_W), .LOG_W(LOG_W)) u_chk (.*);

// File: tb/test_io_port_guard.sv
module test_io_port_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic task_sw = 0, acc_valid = 0, cmd_valid = 0, cmd_grant = 0;
  logic [1:0] task_iopl = 0, acc_size = 0, acc_cpl = 0;
  logic [15:0] acc_port = 0, cmd_base = 0;
  logic [4:0] cmd_log2 = 0;
  logic busy, rsp_valid, rsp_allow, cmd_err;
  logic [1:0] iopl;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_guard i_io_port_guard (.*);

  int vecs = 0, fails = 0;
  string tag = "R1";

  bit granted[int];
  int m_iopl = 0, m_busy = 0;
  bit m_promote = 0, m_rv = 0, m_ra = 0, m_err = 0;

  function automatic bit m_allow(int port, int size, int cpl);
    int nb;
    if (size == 3) return 0;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    if (port + nb - 1 > 65535) return 0;
    if (m_iopl > cpl) return 1;
    for (int p = port; p < port + nb; p++) if (!granted.exists(p)) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted.delete(); m_iopl = 0; m_busy = 0; m_promote = 0;
      m_rv = 0; m_ra = 0; m_err = 0;
    end else begin
      bit was_busy, nrv, nra, nerr;
      was_busy = (m_busy > 0);
      nrv = 0; nra = 0; nerr = 0;
      if (task_sw) begin
        granted.delete(); m_iopl = int'(task_iopl); m_busy = 0; m_promote = 0;
      end else begin
        if (was_busy) begin
          m_busy--;
          if (m_busy == 0 && m_promote) m_iopl = 3;
        end else begin
          if (acc_valid) begin
            nrv = 1;
            nra = m_allow(int'(acc_port), int'(acc_size), int'(acc_cpl));
          end
          if (cmd_valid) begin
            int lg, b, sz;
            lg = int'(cmd_log2); b = int'(cmd_base);
            if (lg > 16 || (b % (1 << lg)) != 0) nerr = 1;
            else begin
              sz = 1 << lg;
              for (int p = b; p < b + sz; p++)
                if (cmd_grant) granted[p] = 1; else granted.delete(p);
              m_busy = (lg > 7) ? (sz >> 7) : 1;
              m_promote = cmd_grant && (granted.num() == 65536);
              if (!cmd_grant && m_iopl == 3) m_iopl = 0;
            end
          end
        end
      end
      m_rv = nrv; m_ra = nra; m_err = nerr;
    end
  end

  task automatic chk(string tg, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tg, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R4 rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv) chk({tag, " rsp_allow"}, int'(rsp_allow), int'(m_ra));
    chk("R9 busy", int'(busy), int'(m_busy > 0));
    chk("R8 cmd_err", int'(cmd_err), int'(m_err));
    chk("R1 R10 R11 iopl", int'(iopl), m_iopl);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_acc(int port, int size, int cpl);
    acc_valid = 1; acc_port = 16'(port); acc_size = 2'(size); acc_cpl = 2'(cpl);
    tick(); acc_valid = 0;
  endtask

  task automatic do_cmd(bit g, int base, int lg);
    cmd_valid = 1; cmd_grant = g; cmd_base = 16'(base); cmd_log2 = 5'(lg);
    tick(); cmd_valid = 0;
  endtask

  task automatic do_sw(int lvl);
    task_sw = 1; task_iopl = 2'(lvl);
    tick(); task_sw = 0;
  endtask

  task automatic wait_idle();
    while (busy) tick();
    tick();
  endtask

  initial begin
    tick(3); rst_n = 1; tick();
    tag = "R1 reset closed"; do_acc('h3F8, 0, 3); tick();

    tag = "R2 R7 single word"; do_cmd(1, 'h3F8, 3); wait_idle();
    do_acc('h3F8, 0, 0); do_acc('h3FF, 0, 0); do_acc('h3F7, 0, 0); do_acc('h400, 0, 3);
    tag = "R5 multi-byte";
    do_acc('h3FC, 2, 0); do_acc('h3FE, 1, 0); do_acc('h3FE, 2, 0); do_acc('h3F8, 3, 0);

    tag = "R8 rejected"; do_cmd(1, 'h501, 1); do_cmd(1, 0, 17); tick();
    do_acc('h501, 0, 0); do_acc('h500, 0, 0);

    tag = "R9 busy ignore"; do_cmd(1, 'h8000, 9);
    do_acc('h3F8, 0, 0); do_cmd(0, 'h8000, 9); wait_idle();
    tag = "R5 R7 word boundary";
    do_acc('h80FE, 2, 0); do_acc('h81FE, 2, 0); do_acc('h81FF, 0, 0); do_acc('h7FFF, 1, 0);

    tag = "R3 R6 bypass"; do_sw(2); tick();
    do_acc('h1234, 0, 1); do_acc('h1234, 2, 0); do_acc('h1234, 0, 2);
    do_acc('hFFFE, 2, 0); do_acc('hFFFF, 1, 1); do_acc('hFFFC, 2, 0);

    tag = "R1 switch cancels"; do_sw(0); do_cmd(1, 'h1000, 12); tick(5); do_sw(0); tick();
    do_acc('h1000, 0, 0); do_acc('h1001, 0, 0);

    tag = "R6 top edge"; do_cmd(1, 'hFF00, 8); wait_idle();
    do_acc('hFFFC, 2, 3); do_acc('hFFFE, 1, 3); do_acc('hFFFD, 2, 3);

    tag = "R10 promote"; do_sw(0); do_cmd(1, 0, 16); wait_idle(); tick();
    do_acc('h4242, 2, 0); do_acc('h4242, 0, 3);
    tag = "R11 demote"; do_cmd(0, 'h10, 0); wait_idle();
    do_acc('h10, 0, 0); do_acc('h11, 0, 0);

    tag = "R12 switch priority";
    acc_valid = 1; acc_port = 16'h11; acc_size = 0; acc_cpl = 0;
    task_sw = 1; task_iopl = 1; tick(); task_sw = 0; acc_valid = 0;
    cmd_valid = 1; cmd_grant = 1; cmd_base = 16'h40; cmd_log2 = 2;
    task_sw = 1; task_iopl = 0; tick(); task_sw = 0; cmd_valid = 0; tick();
    do_acc('h40, 0, 0);

    tag = "R2 R7 same-cycle";
    do_cmd(1, 'h20, 4); wait_idle();
    acc_valid = 1; acc_port = 16'h20; acc_size = 0; acc_cpl = 0;
    cmd_valid = 1; cmd_grant = 0; cmd_base = 16'h20; cmd_log2 = 0;
    tick(); acc_valid = 0; cmd_valid = 0; wait_idle();
    do_acc('h20, 0, 0); do_acc('h21, 0, 0);

    tag = "R2 R5 R7 mixed";
    for (int i = 0; i < 600; i++) begin
      int r, lg, b;
      r = $urandom % 20;
      if (r < 9) begin
        b = (r == 0) ? (16'hFFF0 + $urandom % 16) : ($urandom % 'h1000);
        do_acc(b, $urandom % 4, $urandom % 4);
      end else if (r < 18) begin
        lg = $urandom % 10;
        b = $urandom % 'h1000;
        if ($urandom % 8 != 0) b = b & ~((1 << lg) - 1);
        do_cmd($urandom % 3 != 0, b, lg);
      end else if (r == 18) begin
        acc_valid = 1; acc_port = 16'($urandom % 'h1000); acc_size = 2'($urandom % 3); acc_cpl = 0;
        cmd_valid = 1; cmd_grant = 1'($urandom % 2); cmd_base = 16'h0100; cmd_log2 = 5'd3;
        tick(); acc_valid = 0; cmd_valid = 0;
      end else if ($urandom % 4 == 0) do_sw($urandom % 4);
      else tick();
    end
    wait_idle(); tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule